// File: doc/BRIEF.md
# Interrupt status aggregator

This block collects every interrupt request of a peripheral cluster into one pending-status word and drives a single interrupt line toward the host processor. The low part of the word mirrors the summary request of each GPIO bank as it is right now. Per-pin detail, masking and acknowledge for those pins stay inside the bank. The upper part holds one latched bit per discrete peripheral source. A bit is set by a rising edge on that source, and software clears it by writing a 1 to it.

A control register holds one enable bit per discrete source and a global enable. The host line is meant for a rising-edge-sensitive input. The block registers it, gates it with the global enable, and forces it low for one cycle after every clear write, so that a host that is still busy with other pending work sees a fresh edge. Software reads the status word, services what it finds and repeats until the word is empty.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word reads all zeros in its latched part, the control register reads all zeros (global enable off, every source disabled) and `irq_o` is low.
- R2: Status bits 0 to NUM_BANKS-1 equal `bank_irq_i` in the same cycle, with no latching and no masking. Bit k belongs to bank k, in bank order.
- R3: A rising edge on `src_irq_i[i]` (high at a clock edge after being low at the previous one) sets status bit NUM_BANKS+i in the next cycle. A level that stays high sets nothing further.
- R4: A latched status bit stays set until a status write (`ctl_sel_i`=1) carries a 1 in that bit position. It then reads 0 in the next cycle, unless a new rising edge of that source arrives at the same clock edge; in that case it stays set.
- R5: A status write has no effect on bit positions that carry 0, and no effect on the bank bits 0 to NUM_BANKS-1.
- R6: A control write (`ctl_sel_i`=0) loads the control register from `ctl_wdata_i[NUM_SRC:0]`. Bit 0 is the global enable and bit 1+i enables source i. The register reads back on `mask_o` in the next cycle and holds its value between writes.
- R7: `irq_o` is high in the cycle after a clock edge at which the global enable was set and at least one bank bit or at least one enabled latched bit was set. Otherwise it is low.
- R8: A disabled source still latches and shows in the status word, but it does not drive `irq_o`.
- R9: In the cycle after any status write, `irq_o` is low, even if enabled pending bits remain. It rises again one cycle later if they still remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_irq_i | input | NUM_BANKS | Summary request of each GPIO bank |
| src_irq_i | input | NUM_SRC | Discrete peripheral request lines |
| ctl_wr_i | input | 1 | Write strobe for one cycle |
| ctl_sel_i | input | 1 | Write target: 0 control register, 1 status clear |
| ctl_wdata_i | input | NUM_BANKS+NUM_SRC | Write data |
| status_o | output | NUM_BANKS+NUM_SRC | Pending-status word (banks low, sources above) |
| mask_o | output | NUM_SRC+1 | Control register readback |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The hardest situation to reach is a clear write that lands on the same clock edge as a fresh rising edge of the same source, while other enabled bits stay pending. Here set priority and the forced low gap on `irq_o` interact. The directed part of the stimulus builds this case on purpose: it enables two sources, raises both, then lowers one and raises it again in the same cycle as the clear write for it. A long random phase then toggles bank and source lines at low rates, with scattered control and clear writes, and a behavioural model checks every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic {
      CTL_MASK = 1'b0,
      CTL_STAT = 1'b1
   } ctl_sel_e;
endpackage

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
   parameter int NUM_SRC = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      logic rise;
      logic pend_q;
      assign rise = src_i[i] & ~src_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend_q <= 1'b0;
         else if (rise)   pend_q <= 1'b1;
         else if (clr_i[i]) pend_q <= 1'b0;
      end
      assign pend_o[i] = pend_q;

      a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (src_i[i] && !src_q[i]) |=> pend_o[i]);
      a_r4_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !(src_i[i] && !src_q[i])) |=> !pend_o[i]);
   end
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask #(
   parameter int NUM_SRC = 6,
   localparam int MASK_W = NUM_SRC + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [MASK_W-1:0]  wdata_i,
   output logic               gie_o,
   output logic [NUM_SRC-1:0] src_en_o,
   output logic [MASK_W-1:0]  mask_o
);
   logic [MASK_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign gie_o    = mask_q[0];
   assign src_en_o = mask_q[MASK_W-1:1];
   assign mask_o   = mask_q;

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
   parameter int NUM_BANKS = 4,
   parameter int NUM_SRC   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 gie_i,
   input  logic [NUM_BANKS-1:0] bank_i,
   input  logic [NUM_SRC-1:0]   pend_i,
   input  logic [NUM_SRC-1:0]   src_en_i,
   input  logic                 gap_i,
   output logic                 irq_o
);
   logic any_req;
   logic irq_q;

   assign any_req = (|bank_i) | (|(pend_i & src_en_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= gie_i & any_req & ~gap_i;
   end
   assign irq_o = irq_q;

   a_r9_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
      gap_i |=> !irq_o);
   a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |=> !irq_o);
   a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_i && !gap_i && ((|bank_i) || (|(pend_i & src_en_i)))) |=> irq_o);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
   parameter int NUM_BANKS = 4,
   parameter int NUM_SRC   = 6,
   localparam int STAT_W   = NUM_BANKS + NUM_SRC,
   localparam int MASK_W   = NUM_SRC + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_irq_i,
   input  logic [NUM_SRC-1:0]   src_irq_i,
   input  logic                 ctl_wr_i,
   input  logic                 ctl_sel_i,
   input  logic [STAT_W-1:0]    ctl_wdata_i,
   output logic [STAT_W-1:0]    status_o,
   output logic [MASK_W-1:0]    mask_o,
   output logic                 irq_o
);
   import irq_agg_pkg::*;

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end

   logic               wr_mask;
   logic               wr_stat;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] src_en;
   logic               gie;

   assign wr_mask = ctl_wr_i & (ctl_sel_e'(ctl_sel_i) == CTL_MASK);
   assign wr_stat = ctl_wr_i & (ctl_sel_e'(ctl_sel_i) == CTL_STAT);
   assign clr     = wr_stat ? ctl_wdata_i[STAT_W-1:NUM_BANKS] : '0;

   irq_agg_pend #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_irq_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   irq_agg_mask #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_mask),
      .wdata_i  (ctl_wdata_i[MASK_W-1:0]),
      .gie_o    (gie),
      .src_en_o (src_en),
      .mask_o   (mask_o)
   );

   irq_agg_out #(.NUM_BANKS(NUM_BANKS), .NUM_SRC(NUM_SRC)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .gie_i    (gie),
      .bank_i   (bank_irq_i),
      .pend_i   (pend),
      .src_en_i (src_en),
      .gap_i    (wr_stat),
      .irq_o    (irq_o)
   );

   assign status_o = {pend, bank_irq_i};

   a_r9_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && ctl_sel_i) |=> !irq_o);
   a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(mask_o[0]));
   a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && ctl_sel_i && (ctl_wdata_i[STAT_W-1:NUM_BANKS] == '0))
      |=> ((status_o[STAT_W-1:NUM_BANKS] & $past(status_o[STAT_W-1:NUM_BANKS]))
           == $past(status_o[STAT_W-1:NUM_BANKS])));
endmodule

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb;
   localparam int NB = 4;
   localparam int NS = 6;
   localparam int SW = NB + NS;
   localparam int MW = NS + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] bank = '0;
   logic [NS-1:0] src = '0;
   logic          wr_en = 1'b0;
   logic          sel = 1'b0;
   logic [SW-1:0] wdata = '0;
   logic [SW-1:0] status;
   logic [MW-1:0] mask;
   logic          irq;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   irq_status_agg #(.NUM_BANKS(NB), .NUM_SRC(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .bank_irq_i(bank), .src_irq_i(src),
      .ctl_wr_i(wr_en), .ctl_sel_i(sel), .ctl_wdata_i(wdata),
      .status_o(status), .mask_o(mask), .irq_o(irq)
   );

   // behavioural reference
   bit [NS-1:0] m_pend = '0;
   bit [NS-1:0] m_src_q = '0;
   bit [MW-1:0] m_mask = '0;
   bit          m_irq = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      bit [NS-1:0] edg;
      bit [NS-1:0] clrv;
      bit          act;
      if (!rst_n) begin
         m_pend = '0; m_src_q = '0; m_mask = '0; m_irq = 1'b0;
      end else begin
         edg  = src & ~m_src_q;
         clrv = (wr_en && sel) ? wdata[SW-1:NB] : '0;
         act  = m_mask[0] && ((|bank) || (|(m_pend & m_mask[MW-1:1])));
         m_irq = act && !(wr_en && sel);
         m_pend = (m_pend & ~clrv) | edg;
         m_src_q = src;
         if (wr_en && !sel) m_mask = wdata[MW-1:0];
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(status[NB-1:0] == bank, "R2 bank bits", 32'(status[NB-1:0]), 32'(bank));
      check(status[SW-1:NB] == m_pend, "R3/R4/R5 latched bits", 32'(status[SW-1:NB]), 32'(m_pend));
      check(mask == m_mask, "R6 control readback", 32'(mask), 32'(m_mask));
      check(irq == m_irq, "R7/R8/R9 irq line", 32'(irq), 32'(m_irq));
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input bit s, input logic [SW-1:0] d);
      wr_en = 1'b1; sel = s; wdata = d;
      cyc();
      wr_en = 1'b0; wdata = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(status[SW-1:NB] == '0, "R1 status reset", 32'(status), 32'h0);
      check(mask == '0, "R1 mask reset", 32'(mask), 32'h0);
      check(irq == 1'b0, "R1 irq reset", 32'(irq), 32'h0);

      // R2, R7: bank live, gated by global enable
      bank = 4'b0101; cyc(); cyc();
      check(irq == 1'b0, "R7 no irq with global enable off", 32'(irq), 32'h0);
      wr(1'b0, SW'(7'b0000001)); cyc();
      check(irq == 1'b1, "R7 bank request with global enable", 32'(irq), 32'h1);
      bank = '0; cyc(); cyc();

      // R3, R8: disabled source latches but no irq
      src = 6'b000001; cyc(); cyc();
      check(status[NB] == 1'b1, "R3 source 0 latched", 32'(status[NB]), 32'h1);
      check(irq == 1'b0, "R8 disabled source silent", 32'(irq), 32'h0);
      // R6 enable sources 0 and 1 plus global
      wr(1'b0, SW'(7'b0000111)); cyc();
      check(mask == 7'b0000111, "R6 control load", 32'(mask), 32'h7);
      check(irq == 1'b1, "R7 enabled pending drives irq", 32'(irq), 32'h1);
      src = 6'b000011; cyc(); cyc();
      // R5: write zero and write to bank bits ignored
      wr(1'b1, SW'(10'b0000001111)); cyc();
      check(status[SW-1:NB] == 6'b000011, "R5 bank/zero bits ignored", 32'(status[SW-1:NB]), 32'h3);
      cyc();
      // R9: clear source 0 with source 1 still pending
      wr(1'b1, SW'(10'b0000010000));
      check(irq == 1'b0, "R9 gap after clear", 32'(irq), 32'h0);
      check(status[NB] == 1'b0, "R4 source 0 cleared", 32'(status[NB]), 32'h0);
      cyc();
      check(irq == 1'b1, "R9 irq rises again", 32'(irq), 32'h1);
      // R4: edge on same edge as clear wins
      src = 6'b000010; cyc();
      src = 6'b000011;
      wr(1'b1, SW'(10'b0000010000));
      check(status[NB] == 1'b1, "R4 set beats clear", 32'(status[NB]), 32'h1);
      // R3: steady high sets nothing new after clear
      wr(1'b1, SW'(10'b1111110000)); cyc(); cyc();
      check(status[SW-1:NB] == '0, "R3 held level no re-set", 32'(status[SW-1:NB]), 32'h0);
      check(irq == 1'b0, "R7 empty status no irq", 32'(irq), 32'h0);
      src = '0; cyc();

      // random phase
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 7) == 0) bank = NB'($urandom);
         for (int j = 0; j < NS; j++)
            if ($urandom_range(0, 9) == 0) src[j] = ~src[j];
         if ($urandom_range(0, 5) == 0) begin
            wr_en = 1'b1;
            sel = ($urandom_range(0, 3) != 0);
            wdata = SW'($urandom);
         end
         cyc();
         wr_en = 1'b0; wdata = '0;
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule